// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the control port of a low-power audio converter. An external controller reaches a bank of eleven 8-bit configuration registers through a four-wire serial link in which the block is always the slave. The block runs entirely on the converter's master clock. It samples the serial clock, select and data-in pins through synchronizers and finds serial clock edges by comparing the synchronized level with its value one cycle earlier. Every register is exported as a parallel bus, so the audio path sees a new setting as soon as a write completes. Writes may happen at any time, including during conversion.

A transfer is always 16 bits, most significant bit first, with select held low throughout. The first byte carries a 3-bit operation code in its top bits and a 5-bit register address in its low bits. The second byte is either the write data or a dummy byte during which the register contents are shifted back. Three registers take their reset value from strap levels that the reset controller captures. These levels arrive on a port, and the block loads them in the first clock cycle after reset is released.

Top module: `cfg_spi_regbank`

## Requirements
- R1: While reset is low and after its release, `regs_o` holds 0x48, 0x8F, 0xF0, 0x00, 0x82, 0x00, 0x00 and 0x00 at addresses 0, 1, 2, 3, 5, 6, 7 and 10. Register a sits at `regs_o[8a+7:8a]`.
- R2: After reset release, address 4 holds `strap_def_i[7:0]`, address 8 holds `strap_def_i[15:8]` and address 9 holds `strap_def_i[23:16]`.
- R3: A first byte with bits 7:5 = 100 and bits 4:0 = an address from 0 to 10, followed by a data byte, stores the data byte into that register. The new value appears on `regs_o` after the 16th serial clock rise.
- R4: A first byte with bits 7:5 = 110 and a valid address makes the register appear on `miso_o`, MSB first, during the second byte. Each bit changes after a serial clock fall and is valid at the following rise.
- R5: A first byte whose opcode is neither 110 nor 100 leaves every register unchanged, and the second byte returns 0x00 on `miso_o`.
- R6: An address from 0x0B to 0x1F leaves every register unchanged on a write and returns 0x00 on a read.
- R7: If select rises before 16 bits have been received, no register changes. The next transfer is decoded from its own first bit.
- R8: `miso_oe_o` is high only while select is low. While it is low, `miso_o` is 0.
- R9: `miso_o` is 0 during the whole first byte of every transfer.
- R10: A serial clock rise seen in the same master clock cycle as select going high is not counted. A write whose 16th rise coincides with select release is therefore dropped.
- R11: Serial clock rises after the 16th, while select stays low, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_def_i | input | 24 | Strap defaults for addresses 4, 8, 9 (low byte first) |
| sck_i | input | 1 | Serial clock from the controller |
| ss_n_i | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data into the block |
| miso_o | output | 1 | Serial read data |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| regs_o | output | 88 | All registers, address a at bits 8a+7:8a |

## Verification
The 16th serial clock rise and the release of select can land in the same master clock cycle, which puts the write strobe and the frame abort in competition. The bench provokes this by raising both pins between the same pair of clock edges. Both pins then pass through synchronizers of equal depth and reach the frame logic together. The result is judged at the ports: the target register must keep its old value on `regs_o`, and the next normal transfer must both write and read back correctly.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FRAME_BITS  = 2 * BYTE_W;
  localparam int unsigned ADDR_W      = 5;
  localparam int unsigned STRAP_SLOTS = 3;
  localparam int unsigned STRAP_W     = STRAP_SLOTS * BYTE_W;

  localparam logic [2:0] OP_RD = 3'b110;
  localparam logic [2:0] OP_WR = 3'b100;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic [2:0]        op;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  // reset value of a register that does not come from a strap
  function automatic byte_t fixed_default(int unsigned idx);
    case (idx)
      0:       return 8'h48;
      1:       return 8'h8F;
      2:       return 8'hF0;
      5:       return 8'h82;
      default: return 8'h00;
    endcase
  endfunction

  // strap byte that feeds a register, or -1 for a fixed default
  function automatic int strap_slot(int unsigned idx);
    case (idx)
      4:       return 0;
      8:       return 1;
      9:       return 2;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int unsigned WIDTH            = 3,
  parameter int unsigned STAGES           = 2,
  parameter logic [WIDTH-1:0] RESET_VAL   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    assign stg_d = {stg_q[STAGES-2:0], d_i[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RESET_VAL[b]}};
      else        stg_q <= stg_d;
    end

    assign q_o[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
  import cfg_spi_pkg::*;
#(
  parameter int unsigned NUM_REGS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_act_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  byte_t             rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output byte_t             wr_data_o,
  output logic              miso_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  cmd_t              cmd_q, cmd_d;
  byte_t             tx_q, tx_d;
  logic              miso_q, miso_d;
  logic              wr_en_q, wr_en_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  byte_t             wr_data_q, wr_data_d;

  byte_t byte_in;
  cmd_t  cmd_in;
  logic  frame_full;

  function automatic logic addr_ok(logic [ADDR_W-1:0] a);
    return 32'(a) < 32'(NUM_REGS);
  endfunction

  assign byte_in    = {sh_q, mosi_i};
  assign cmd_in     = cmd_t'(byte_in);
  assign frame_full = (cnt_q == CNT_FULL);
  assign rd_addr_o  = cmd_in.addr;

  always_comb begin
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    cmd_d     = cmd_q;
    tx_d      = tx_q;
    miso_d    = miso_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    if (!ss_act_i) begin
      cnt_d  = '0;
      sh_d   = '0;
      tx_d   = '0;
      miso_d = 1'b0;
    end else begin
      if (sck_rise_i && !frame_full) begin
        sh_d  = byte_in[BYTE_W-2:0];
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_CMD) begin
          cmd_d = cmd_in;
          tx_d  = (cmd_in.op == OP_RD && addr_ok(cmd_in.addr)) ? rd_data_i : '0;
        end
        if (cnt_q == CNT_LAST && cmd_q.op == OP_WR && addr_ok(cmd_q.addr)) begin
          wr_en_d   = 1'b1;
          wr_addr_d = cmd_q.addr;
          wr_data_d = byte_in;
        end
      end
      if (sck_fall_i) begin
        miso_d = tx_q[BYTE_W-1];
        tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      cmd_q     <= cmd_t'('0);
      tx_q      <= '0;
      miso_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      cmd_q     <= cmd_d;
      tx_q      <= tx_d;
      miso_q    <= miso_d;
      wr_en_q   <= wr_en_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign miso_o    = miso_q;
endmodule

// File: rtl/cfg_spi_bank.sv
module cfg_spi_bank
  import cfg_spi_pkg::*;
#(
  parameter int unsigned NUM_REGS = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [STRAP_W-1:0]         strap_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  byte_t                      wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output byte_t                      rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic                       init_q;
  logic [NUM_REGS*BYTE_W-1:0] bank_flat;

  // one-cycle window after reset release in which strap bytes load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b1;
    else        init_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam int SLOT = strap_slot(g);
    byte_t q, d;
    logic  hit;

    assign hit = wr_en_i && (32'(wr_addr_i) == 32'(g));

    if (SLOT >= 0) begin : g_strap
      always_comb begin
        d = q;
        if (init_q) d = strap_i[SLOT*BYTE_W +: BYTE_W];
        if (hit)    d = wr_data_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_fixed
      always_comb begin
        d = q;
        if (hit) d = wr_data_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= fixed_default(g);
        else        q <= d;
      end
    end

    assign bank_flat[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (32'(rd_addr_i) == 32'(i)) rd_data_o = bank_flat[i*BYTE_W +: BYTE_W];
    end
  end

  assign regs_o = bank_flat;
endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank
  import cfg_spi_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [STRAP_W-1:0]         strap_def_i,
  input  logic                       sck_i,
  input  logic                       ss_n_i,
  input  logic                       mosi_i,
  output logic                       miso_o,
  output logic                       miso_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_SS   = 1;
  localparam int unsigned PIN_MOSI = 2;

  logic [2:0]        pins_s;
  logic              sck_prev_q;
  logic              sck_rise, sck_fall, ss_act;
  logic              miso_q;
  logic [ADDR_W-1:0] rd_addr;
  byte_t             rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  byte_t             wr_data;

  cfg_spi_sync #(
    .WIDTH     (3),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({mosi_i, ss_n_i, sck_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= pins_s[PIN_SCK];
  end

  assign sck_rise = pins_s[PIN_SCK] & ~sck_prev_q;
  assign sck_fall = ~pins_s[PIN_SCK] & sck_prev_q;
  assign ss_act   = ~pins_s[PIN_SS];

  cfg_spi_frame #(.NUM_REGS(NUM_REGS)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_act_i   (ss_act),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .mosi_i     (pins_s[PIN_MOSI]),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .miso_o     (miso_q)
  );

  cfg_spi_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_i   (strap_def_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );

  assign miso_oe_o = ss_act;
  assign miso_o    = miso_q & ss_act;
endmodule

// File: rtl/cfg_spi_regbank_chk.sv
module cfg_spi_regbank_chk
  import cfg_spi_pkg::*;
#(
  parameter int unsigned NUM_REGS = 11
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic                       sck_fall,
  input logic                       ss_act,
  input logic                       miso_o,
  input logic                       miso_oe_o,
  input logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic [1:0] settle_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 settle_q <= 2'd0;
    else if (settle_q != 2'd2)  settle_q <= settle_q + 2'd1;
  end
  assign armed = (settle_q == 2'd2);

  // R3 / R7 / R11: the bank moves only one cycle after a write strobe
  a_r3_regs_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(wr_en)) |-> $stable(regs_o));

  // R6: no strobe ever targets an unmapped address
  a_r6_strobe_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < 32'(NUM_REGS)));

  // R10: a strobe comes only from a cycle in which select was active
  a_r10_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(ss_act));

  // R8: data line quiet whenever it is not driven
  a_r8_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe_o |-> !miso_o);

  // R4: within a transfer the data line moves only after a clock fall
  a_r4_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe_o && $past(miso_oe_o) && !$past(sck_fall)) |-> $stable(miso_o));
endmodule

bind cfg_spi_regbank cfg_spi_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .sck_fall  (sck_fall),
  .ss_act    (ss_act),
  .miso_o    (miso_o),
  .miso_oe_o (miso_oe_o),
  .regs_o    (regs_o)
);

// File: tb/cfg_spi_regbank_tb.sv
module cfg_spi_regbank_tb;
  localparam int NREG = 11;
  localparam int H    = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, sck, ss_n, mosi;
  logic [23:0]       strap = 24'h25_01_0C;
  logic              miso, miso_oe;
  logic [NREG*8-1:0] regs;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [7:0] exp_q [NREG];

  cfg_spi_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .strap_def_i(strap), .sck_i(sck), .ss_n_i(ss_n),
    .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe), .regs_o(regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] base_val(int a);
    case (a)
      0: return 8'h48;  1: return 8'h8F;  2: return 8'hF0;  5: return 8'h82;
      4: return strap[7:0]; 8: return strap[15:8]; 9: return strap[23:16];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] read_expect(logic [7:0] cmd);
    if (cmd[7:5] == 3'b110 && cmd[4:0] < 5'd11) return exp_q[cmd[4:0]];
    return 8'h00;
  endfunction

  function automatic void apply_write(logic [7:0] cmd, logic [7:0] data);
    if (cmd[7:5] == 3'b100 && cmd[4:0] < 5'd11) exp_q[cmd[4:0]] = data;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    for (int a = 0; a < NREG; a++) chk(tag, 32'(regs[a*8 +: 8]), 32'(exp_q[a]));
  endtask

  task automatic send_bits(input logic [23:0] bits, input int n, output logic [23:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      mosi = bits[n-1-i];
      wait_clk(H);
      rx = {rx[22:0], miso};
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] b1, input logic [7:0] b2, output logic [15:0] rx);
    logic [23:0] r;
    ss_n = 1'b0;
    wait_clk(H);
    send_bits({8'h00, b1, b2}, 16, r);
    wait_clk(H);
    ss_n = 1'b1;
    wait_clk(8);
    rx = r[15:0];
  endtask

  task automatic xfer_check(input string tag, input logic [7:0] b1, input logic [7:0] b2);
    logic [15:0] rx;
    logic [7:0]  er;
    er = read_expect(b1);
    frame(b1, b2, rx);
    chk({tag, " rd"}, 32'(rx[7:0]), 32'(er));
    chk("R9 first byte quiet", 32'(rx[15:8]), 32'h0);
    apply_write(b1, b2);
    check_regs({tag, " regs"});
  endtask

  initial begin
    int unsigned seed;
    logic [15:0] rx;
    logic [23:0] r;
    seed = 32'h00C0FFEE;
    void'($urandom(seed));
    rst_n = 1'b0; sck = 1'b0; ss_n = 1'b1; mosi = 1'b0;
    wait_clk(5);
    chk("R1 default in reset a0", 32'(regs[7:0]), 32'h48);
    chk("R1 default in reset a5", 32'(regs[47:40]), 32'h82);
    chk("R8 oe low idle", 32'(miso_oe), 32'h0);
    rst_n = 1'b1;
    wait_clk(4);
    for (int a = 0; a < NREG; a++) exp_q[a] = base_val(a);
    check_regs("R1 R2 after reset");

    // R3 / R4 directed
    xfer_check("R3 write a2", 8'h82, 8'hC4);
    xfer_check("R4 read a2", 8'hC2, 8'h00);
    xfer_check("R4 read a9 strap", 8'hC9, 8'hA5);
    xfer_check("R3 write a10", 8'h8A, 8'h3E);
    // R5 bad opcodes
    xfer_check("R5 bad op write", 8'hA2, 8'h11);
    xfer_check("R5 bad op read", 8'hE2, 8'h00);
    // R6 out of range
    xfer_check("R6 write a11", 8'h8B, 8'h55);
    xfer_check("R6 read a31", 8'hDF, 8'h00);

    // R7 abort after 10 and after 15 bits
    ss_n = 1'b0; wait_clk(H);
    send_bits({8'h00, 8'h83, 8'h99}, 10, r);
    wait_clk(H); ss_n = 1'b1; wait_clk(8);
    check_regs("R7 abort 10 bits");
    ss_n = 1'b0; wait_clk(H);
    send_bits({9'h0, 15'h4299}, 15, r);
    wait_clk(H); ss_n = 1'b1; wait_clk(8);
    check_regs("R7 abort 15 bits");
    xfer_check("R7 frame after abort", 8'h83, 8'h3C);

    // R8 enable follows select
    ss_n = 1'b0; wait_clk(H);
    chk("R8 oe high when selected", 32'(miso_oe), 32'h1);
    ss_n = 1'b1; wait_clk(5);
    chk("R8 oe low when released", 32'(miso_oe), 32'h0);
    chk("R8 miso low when released", 32'(miso), 32'h0);

    // R10 last rise together with select release
    ss_n = 1'b0; wait_clk(H);
    send_bits({9'h0, 15'h433B}, 15, r);
    mosi = 1'b1;
    wait_clk(H);
    sck = 1'b1; ss_n = 1'b1;
    wait_clk(H);
    sck = 1'b0;
    wait_clk(8);
    check_regs("R10 coincident release");
    xfer_check("R10 frame after", 8'h86, 8'h77);
    xfer_check("R10 readback", 8'hC6, 8'h00);

    // R11 extra byte while selected
    ss_n = 1'b0; wait_clk(H);
    send_bits({8'h87, 8'h5A, 8'hFF}, 24, r);
    wait_clk(H); ss_n = 1'b1; wait_clk(8);
    exp_q[7] = 8'h5A;
    check_regs("R11 extra bits");

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [2:0] op;
      logic [7:0] b1, b2;
      int unsigned sel;
      sel = $urandom % 4;
      b2  = 8'($urandom);
      case (sel)
        0, 1: op = 3'b100;
        2:    op = 3'b110;
        default: begin
          op = 3'($urandom);
          if (op == 3'b110 || op == 3'b100) op = 3'b111;
        end
      endcase
      b1 = {op, 5'($urandom % 16)};
      xfer_check("R3 R4 R5 R6 random", b1, b2);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule